// File: doc/BRIEF.md
# Master-ID Peripheral Access Filter

The filter stands between an on-chip interconnect and a group of peripherals. Each access arrives with an address, a read/write control bit and a 4-bit identifier naming the master that issued it. The upper bits of the address choose one peripheral window. The identifier is expanded into a 16-bit one-hot vector and compared with that peripheral's own 16-bit permission mask. The peripheral select is raised only when the window matches and the mask bit for the requesting master is set.

A refused access drives no select and returns a protection error instead. The identifier and peripheral index of the first refused access are held in a capture register behind a sticky violation flag until software clears it. An address outside every window returns a separate decode error. Software writes the permission masks through a small configuration port. From reset every mask is all ones, so all masters reach all peripherals until software restricts them.

Each peripheral owns a window of 2^WIN_BITS bytes. Peripheral i answers when address bits [ADDR_W-1:WIN_BITS] equal PAGE_BASE+i. With the defaults (16-bit address, 12 offset bits, base page 2, six peripherals) pages 2 to 7 map to peripherals 0 to 5, and all other pages are unmapped.

Top module: `mid_access_filter`

## Requirements
- R1: After reset all outputs are 0, the violation flag is clear, and every permission mask reads as all ones, so any master reaches any peripheral.
- R2: A valid access whose page equals PAGE_BASE+i asserts per_sel bit i alone one cycle later. per_addr then carries address bits [WIN_BITS-1:0] and per_write carries acc_write.
- R3: A valid access to a page outside PAGE_BASE..PAGE_BASE+NUM_PERIPH-1 raises rsp_dec_err one cycle later with per_sel 0 and rsp_prot_err 0. It leaves the violation flag and capture untouched.
- R4: Bit k of peripheral i's mask set to 1 lets master k (acc_mid = k) reach peripheral i.
- R5: Bit k cleared to 0 refuses master k. One cycle later per_sel, per_write and per_addr are 0 and rsp_prot_err is 1.
- R6: A refused access while the flag is clear sets viol_flag in the same cycle as rsp_prot_err. It stores acc_mid in viol_mid and the peripheral index in viol_pidx.
- R7: While the flag is set, later refusals leave viol_mid and viol_pidx unchanged. cfg_clr drops the flag one cycle later. A refusal in the same cycle as cfg_clr keeps the flag set and captures the new refusal.
- R8: A write with cfg_we=1, cfg_idx=i and cfg_wdata=m loads mask i with m. The new mask governs accesses presented from the next cycle on. An access in the same cycle as the write is judged by the old mask.
- R9: A configuration write with cfg_idx >= NUM_PERIPH changes no mask.
- R10: In a cycle following acc_valid=0, per_sel, per_write, per_addr, rsp_prot_err and rsp_dec_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_mid | input | 4 | Identifier of the issuing master |
| cfg_we | input | 1 | Permission mask write strobe |
| cfg_idx | input | IDX_W | Peripheral whose mask is written |
| cfg_wdata | input | 16 | New mask; bit k governs master k |
| cfg_clr | input | 1 | Clear the sticky violation flag |
| per_sel | output | NUM_PERIPH | One-hot peripheral select |
| per_write | output | 1 | Write control forwarded to the peripheral |
| per_addr | output | WIN_BITS | Offset within the selected window |
| rsp_prot_err | output | 1 | Access refused by the permission mask |
| rsp_dec_err | output | 1 | Address matched no window |
| viol_flag | output | 1 | Sticky refusal flag |
| viol_mid | output | 4 | Master of the captured refusal |
| viol_pidx | output | IDX_W | Peripheral of the captured refusal |

## Verification
Every result is registered once. A select, forwarded control, error response or capture update caused by the inputs sampled at one rising edge is visible just after that edge, and stays until the next. The bench changes inputs at the falling edge and checks all outputs 1 ns after the following rising edge. It judges against a mask model that has not yet taken that cycle's configuration write, and only then applies the write. This order is the one R8 fixes for a write and an access in the same cycle. Flag and capture expectations follow the same edge, so a refusal and its capture are checked in one sample.

// File: rtl/maf_pkg.sv
// Shared types for the master-ID access filter.
// Assumes master identifiers are 4 bits wide, giving 16 distinct masters.
package maf_pkg;

    localparam int MID_W   = 4;
    localparam int NUM_MID = 1 << MID_W;

    typedef logic [MID_W-1:0]   mid_t;
    typedef logic [NUM_MID-1:0] perm_t;

    // Expand a master identifier to its one-hot position.
    function automatic perm_t mid_onehot(input mid_t mid);
        perm_t v;
        v = '0;
        v[mid] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/maf_window_decode.sv
// Address window decoder.
// Peripheral i owns page PAGE_BASE+i, where a page is the address above the
// low WIN_BITS bits. Purely combinational. Assumes
// PAGE_BASE+NUM_PERIPH <= 2**(ADDR_W-WIN_BITS) and NUM_PERIPH >= 2.
module maf_window_decode #(
    parameter int ADDR_W     = 16,
    parameter int WIN_BITS   = 12,
    parameter int NUM_PERIPH = 6,
    parameter int PAGE_BASE  = 2,
    localparam int IDX_W     = $clog2(NUM_PERIPH),
    localparam int PAGE_W    = ADDR_W - WIN_BITS
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic                  hit,
    output logic [IDX_W-1:0]      idx,
    output logic [NUM_PERIPH-1:0] sel
);

    logic [PAGE_W-1:0] page;

    assign page = addr[ADDR_W-1:WIN_BITS];

    // One comparator per peripheral window.
    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_win
        localparam logic [PAGE_W-1:0] MY_PAGE = PAGE_W'(PAGE_BASE + i);
        assign sel[i] = (page == MY_PAGE);
    end

    assign hit = |sel;

    // Encode the matching window into a peripheral index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_PERIPH; i++) begin
            if (sel[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/maf_perm_bank.sv
// Bank of per-peripheral permission masks.
// Resets every mask to all ones. A write to an index at or above NUM_PERIPH
// is dropped. The read port is combinational and returns the current mask
// of rd_idx (zero for an unused index).
module maf_perm_bank
    import maf_pkg::*;
#(
    parameter int NUM_PERIPH = 6,
    localparam int IDX_W     = $clog2(NUM_PERIPH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  perm_t            wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output perm_t            rd_perm
);

    perm_t mask_q [NUM_PERIPH];

    // One mask register per peripheral.
    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_mask
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
        // Load the mask on a matching write, open to all after reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[i] <= '1;
            end else if (wr_en && (wr_idx == MY_IDX)) begin
                mask_q[i] <= wr_data;
            end
        end
    end

    // Select the mask of the addressed peripheral.
    always_comb begin
        rd_perm = '0;
        for (int i = 0; i < NUM_PERIPH; i++) begin
            if (rd_idx == IDX_W'(i)) rd_perm = mask_q[i];
        end
    end

endmodule

// File: rtl/maf_capture.sv
// Sticky violation capture.
// Stores the master and peripheral of a refusal while the flag is clear and
// holds them until clr. A refusal coincident with clr wins, so it is
// captured and the flag stays set.
module maf_capture
    import maf_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             deny,
    input  mid_t             deny_mid,
    input  logic [IDX_W-1:0] deny_idx,
    input  logic             clr,
    output logic             flag,
    output mid_t             cap_mid,
    output logic [IDX_W-1:0] cap_idx
);

    logic take;

    assign take = deny && (!flag || clr);

    // Track the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag <= 1'b0;
        else if (deny)  flag <= 1'b1;
        else if (clr)   flag <= 1'b0;
    end

    // Record the offending master and peripheral.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_mid <= '0;
            cap_idx <= '0;
        end else if (take) begin
            cap_mid <= deny_mid;
            cap_idx <= deny_idx;
        end
    end

endmodule

// File: rtl/mid_access_filter.sv
// Master-ID peripheral access filter (top).
// Decodes the address to a peripheral window and checks the master's bit in
// that peripheral's mask. It registers the select, forwarded control and
// error responses one cycle after the access. Assumes one access per cycle
// and that a refusal or decode error needs no retry handling here.
module mid_access_filter
    import maf_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int WIN_BITS   = 12,
    parameter int NUM_PERIPH = 6,
    parameter int PAGE_BASE  = 2,
    localparam int IDX_W     = $clog2(NUM_PERIPH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic                  acc_write,
    input  logic [MID_W-1:0]      acc_mid,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic [NUM_MID-1:0]    cfg_wdata,
    input  logic                  cfg_clr,
    output logic [NUM_PERIPH-1:0] per_sel,
    output logic                  per_write,
    output logic [WIN_BITS-1:0]   per_addr,
    output logic                  rsp_prot_err,
    output logic                  rsp_dec_err,
    output logic                  viol_flag,
    output logic [MID_W-1:0]      viol_mid,
    output logic [IDX_W-1:0]      viol_pidx
);

    logic                  win_hit;
    logic [IDX_W-1:0]      win_idx;
    logic [NUM_PERIPH-1:0] win_sel;
    perm_t                 cur_perm;
    logic                  allowed;
    logic                  grant;
    logic                  deny;

    maf_window_decode #(
        .ADDR_W     (ADDR_W),
        .WIN_BITS   (WIN_BITS),
        .NUM_PERIPH (NUM_PERIPH),
        .PAGE_BASE  (PAGE_BASE)
    ) u_dec (
        .addr (acc_addr),
        .hit  (win_hit),
        .idx  (win_idx),
        .sel  (win_sel)
    );

    maf_perm_bank #(
        .NUM_PERIPH (NUM_PERIPH)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_data (cfg_wdata),
        .rd_idx  (win_idx),
        .rd_perm (cur_perm)
    );

    // Look up the requesting master's bit in the addressed mask.
    always_comb begin
        allowed = |(mid_onehot(acc_mid) & cur_perm);
        grant   = acc_valid && win_hit && allowed;
        deny    = acc_valid && win_hit && !allowed;
    end

    maf_capture #(
        .IDX_W (IDX_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .deny     (deny),
        .deny_mid (acc_mid),
        .deny_idx (win_idx),
        .clr      (cfg_clr),
        .flag     (viol_flag),
        .cap_mid  (viol_mid),
        .cap_idx  (viol_pidx)
    );

    // Register peripheral-side outputs and the error responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_sel      <= '0;
            per_write    <= 1'b0;
            per_addr     <= '0;
            rsp_prot_err <= 1'b0;
            rsp_dec_err  <= 1'b0;
        end else begin
            per_sel      <= grant ? win_sel : '0;
            per_write    <= grant && acc_write;
            per_addr     <= grant ? acc_addr[WIN_BITS-1:0] : '0;
            rsp_prot_err <= deny;
            rsp_dec_err  <= acc_valid && !win_hit;
        end
    end

endmodule

// File: rtl/maf_checker.sv
// Assertion checker for mid_access_filter, attached by bind.
// Observes ports only. Assumes the same parameters as the bound instance.
module maf_checker #(
    parameter int ADDR_W     = 16,
    parameter int WIN_BITS   = 12,
    parameter int NUM_PERIPH = 6,
    parameter int PAGE_BASE  = 2,
    localparam int IDX_W     = $clog2(NUM_PERIPH),
    localparam int PAGE_W    = ADDR_W - WIN_BITS
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  acc_valid,
    input logic [ADDR_W-1:0]     acc_addr,
    input logic                  cfg_clr,
    input logic [NUM_PERIPH-1:0] per_sel,
    input logic                  per_write,
    input logic                  rsp_prot_err,
    input logic                  rsp_dec_err,
    input logic                  viol_flag,
    input logic [3:0]            viol_mid,
    input logic [IDX_W-1:0]      viol_pidx
);

    logic [PAGE_W-1:0] pg;
    logic              unmapped;

    assign pg       = acc_addr[ADDR_W-1:WIN_BITS];
    assign unmapped = (int'(pg) < PAGE_BASE) || (int'(pg) >= PAGE_BASE + NUM_PERIPH);

    assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(per_sel));

    assert_unmapped_dec_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && unmapped |=> rsp_dec_err && per_sel == '0 && !rsp_prot_err);

    assert_err_blocks_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_prot_err |-> per_sel == '0 && !per_write && !rsp_dec_err);

    assert_flag_rise_with_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol_flag) |-> rsp_prot_err);

    assert_capture_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(viol_flag) && !$past(cfg_clr) |-> $stable(viol_mid) && $stable(viol_pidx) && viol_flag);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> per_sel == '0 && !per_write && !rsp_prot_err && !rsp_dec_err);

endmodule

bind mid_access_filter maf_checker #(
    .ADDR_W     (ADDR_W),
    .WIN_BITS   (WIN_BITS),
    .NUM_PERIPH (NUM_PERIPH),
    .PAGE_BASE  (PAGE_BASE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_addr     (acc_addr),
    .cfg_clr      (cfg_clr),
    .per_sel      (per_sel),
    .per_write    (per_write),
    .rsp_prot_err (rsp_prot_err),
    .rsp_dec_err  (rsp_dec_err),
    .viol_flag    (viol_flag),
    .viol_mid     (viol_mid),
    .viol_pidx    (viol_pidx)
);

// File: tb/mid_access_filter_test.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases, then seeded random traffic,
// compared against a behavioural model of masks and capture.
module mid_access_filter_test;

    localparam int ADDR_W = 16;
    localparam int WIN_BITS = 12;
    localparam int NP = 6;
    localparam int PB = 2;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic acc_write = 1'b0;
    logic [3:0] acc_mid = '0;
    logic cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [15:0] cfg_wdata = '0;
    logic cfg_clr = 1'b0;
    logic [NP-1:0] per_sel;
    logic per_write;
    logic [WIN_BITS-1:0] per_addr;
    logic rsp_prot_err, rsp_dec_err, viol_flag;
    logic [3:0] viol_mid;
    logic [IW-1:0] viol_pidx;

    int checks = 0;
    int failures = 0;

    logic [15:0] m_perm [NP];
    logic m_flag;
    logic [3:0] m_mid;
    logic [IW-1:0] m_pidx;

    always #2.5 clk = ~clk;

    mid_access_filter uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_mid(acc_mid), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_clr(cfg_clr), .per_sel(per_sel), .per_write(per_write),
        .per_addr(per_addr), .rsp_prot_err(rsp_prot_err), .rsp_dec_err(rsp_dec_err),
        .viol_flag(viol_flag), .viol_mid(viol_mid), .viol_pidx(viol_pidx)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk_addr(input int page, input int off);
        return {4'(page), 12'(off)};
    endfunction

    // One cycle: drive at the falling edge, check after the rising edge.
    task automatic step(input string tag, input logic v, input logic [ADDR_W-1:0] a, input logic w,
                        input logic [3:0] m, input logic we, input logic [IW-1:0] ix,
                        input logic [15:0] wd, input logic clr);
        int pg;
        int pi;
        logic inr, alw, deny;
        logic [NP-1:0] e_sel;
        @(negedge clk);
        acc_valid = v; acc_addr = a; acc_write = w; acc_mid = m;
        cfg_we = we; cfg_idx = ix; cfg_wdata = wd; cfg_clr = clr;
        @(posedge clk);
        #1;
        pg  = int'(a[ADDR_W-1:WIN_BITS]);
        inr = (pg >= PB) && (pg < PB + NP);
        pi  = inr ? pg - PB : 0;
        alw = inr && m_perm[pi][m];
        deny = v && inr && !alw;
        e_sel = (v && alw) ? NP'(1 << pi) : '0;
        if (deny && (!m_flag || clr)) begin
            m_mid = m;
            m_pidx = IW'(pi);
        end
        if (deny) m_flag = 1'b1;
        else if (clr) m_flag = 1'b0;
        chk(tag, "per_sel", 32'(per_sel), 32'(e_sel));
        chk(tag, "per_write", 32'(per_write), 32'(v && alw && w));
        chk(tag, "per_addr", 32'(per_addr), (v && alw) ? 32'(a[WIN_BITS-1:0]) : 32'd0);
        chk(tag, "rsp_prot_err", 32'(rsp_prot_err), 32'(deny));
        chk(tag, "rsp_dec_err", 32'(rsp_dec_err), 32'(v && !inr));
        chk(tag, "viol_flag", 32'(viol_flag), 32'(m_flag));
        chk(tag, "viol_mid", 32'(viol_mid), 32'(m_mid));
        chk(tag, "viol_pidx", 32'(viol_pidx), 32'(m_pidx));
        if (we && int'(ix) < NP) m_perm[ix] = wd;
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NP; i++) m_perm[i] = 16'hFFFF;
        m_flag = 1'b0; m_mid = '0; m_pidx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1: reset state visible on every output
        chk("R1", "per_sel", 32'(per_sel), 0);
        chk("R1", "rsp_prot_err", 32'(rsp_prot_err), 0);
        chk("R1", "rsp_dec_err", 32'(rsp_dec_err), 0);
        chk("R1", "viol_flag", 32'(viol_flag), 0);

        step("R10", 0, mk_addr(3, 'h55), 1, 4'd2, 0, 0, 0, 0);
        for (int i = 0; i < NP; i++)
            step("R2", 1, mk_addr(PB + i, 'h0A5 + i), logic'(i % 2), 4'd0, 0, 0, 0, 0);
        for (int m = 0; m < 16; m++)
            step("R1", 1, mk_addr(PB + m % NP, 'h123), 0, 4'(m), 0, 0, 0, 0);
        step("R3", 1, mk_addr(0, 'h001), 1, 4'd1, 0, 0, 0, 0);
        step("R3", 1, mk_addr(1, 'hFFF), 0, 4'd2, 0, 0, 0, 0);
        step("R3", 1, mk_addr(8, 'h000), 0, 4'd3, 0, 0, 0, 0);
        step("R3", 1, mk_addr(15, 'h777), 1, 4'd4, 0, 0, 0, 0);
        // R8: same-cycle write does not affect this access
        step("R8", 1, mk_addr(4, 'h010), 1, 4'd7, 1, 3'd2, 16'hFF7F, 0);
        step("R5 R6", 1, mk_addr(4, 'h011), 1, 4'd7, 0, 0, 0, 0);
        step("R4", 1, mk_addr(4, 'h012), 1, 4'd5, 0, 0, 0, 0);
        step("R8", 0, 0, 0, 0, 1, 3'd0, 16'h0000, 0);
        step("R7", 1, mk_addr(2, 'h020), 0, 4'd3, 0, 0, 0, 0);
        step("R7", 0, 0, 0, 0, 0, 0, 0, 1);
        step("R7", 1, mk_addr(2, 'h021), 0, 4'd9, 0, 0, 0, 1);
        step("R7", 0, 0, 0, 0, 0, 0, 0, 1);
        step("R9", 0, 0, 0, 0, 1, 3'd7, 16'h0000, 0);
        step("R9", 0, 0, 0, 0, 1, 3'd6, 16'h0000, 0);
        step("R9", 1, mk_addr(3, 'h100), 0, 4'd12, 0, 0, 0, 0);
        step("R9", 1, mk_addr(5, 'h101), 1, 4'd12, 0, 0, 0, 0);
        step("R9", 1, mk_addr(6, 'h102), 0, 4'd12, 0, 0, 0, 0);
        step("R9", 1, mk_addr(7, 'h103), 1, 4'd12, 0, 0, 0, 0);

        for (int n = 0; n < 600; n++) begin
            int pg;
            logic [15:0] wd;
            pg = ($urandom % 4 == 0) ? int'($urandom % 16) : PB + int'($urandom % NP);
            wd = ($urandom % 2 == 0) ? 16'($urandom) : ~(16'd1 << ($urandom % 16));
            step("R4 R5 random", logic'($urandom % 5 != 0), mk_addr(pg, int'($urandom % 4096)),
                 logic'($urandom % 2), 4'($urandom % 16), logic'($urandom % 7 == 0),
                 3'($urandom % 8), wd, logic'($urandom % 20 == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule